// File: doc/BRIEF.md
# Clock Buffer Serial Configuration Slave

This block is the configuration port of a multi-output clock buffer. It oversamples the two serial bus lines with a fast system clock and behaves as a fixed-address bus slave. It holds six 8-bit configuration registers. Ten of their bits become per-pair output enables. It drives SDA only by pulling it low through an output-enable pin. It never stretches the clock.

The slave supports block transfers only, and every transfer starts at register 0. On a write, the host sends the address, a command byte and a count byte. The slave acknowledges both of those bytes and throws them away. The data that follows fills the registers in ascending order. On a read, the slave returns a byte count and then the registers in ascending order until the host withholds its acknowledge. Bit rates of 100 kbit/s and below are the intended range. The system clock must be much faster than SCL.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, registers 0 to 4 read 0xFF, register 5 reads 0x06, all ten enables are 1 and `sda_oe_o` is 0.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69 with R/W in bit 0. For any other address it stays silent until the next START or STOP.
- R3: In a write, the two bytes after the address are acknowledged and change no register.
- R4: The data bytes of a write are acknowledged and stored in register 0, 1, 2 and so on, in arrival order.
- R5: A STOP after any whole byte keeps the registers already written and leaves the rest unchanged.
- R6: A read returns the count 0x06 first and then registers 0 to 5. Each byte is sent MSB first, and the next byte is sent only after the host acknowledges.
- R7: Bytes read after register 5 are 0xFF, because the line is left released.
- R8: When the host does not acknowledge a read byte, the slave releases SDA until a START or STOP.
- R9: A START or repeated START sends the next transfer back to the address phase. The register pointer returns to 0 and the header count restarts.
- R10: Write data bytes beyond register 5 are acknowledged and discarded.
- R11: `pair_en_o[k]` equals register 0 bit 7-k for k = 0..7. `pair_en_o[8]` equals register 1 bit 7 and `pair_en_o[9]` equals register 1 bit 6.
- R12: `sda_oe_o` only ever pulls SDA low. It is asserted only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pair_en_o | output | 10 | Output pair enables, 1 = enabled |

## Verification
A corrupted register or a write pointer that has slipped shows at `pair_en_o` at the end of the affected byte. It also shows in the next block read, where every register is returned in order. A wrong byte phase or header count misplaces the data by whole registers. A bad acknowledge or drive decision shows within one SCL period as a missing or extra low on the data line. The bench models the wired-AND bus and checks every acknowledge bit. It also compares the enable vector with its own register model on every clock.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned NUM_REGS    = 6;
  localparam int unsigned NUM_PAIRS   = 10;
  localparam int unsigned HDR_BYTES   = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [6:0]  DEV_ADDR    = 7'h69;
  localparam logic [7:0]  BLOCK_COUNT = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } smb_state_e;

  function automatic logic [7:0] reg_reset(int unsigned idx, int unsigned n);
    return (idx == n - 1) ? 8'h06 : 8'hFF;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [0] = scl, [1] = sda; last entry holds the previous sample
  logic [STAGES:0][1:0] pipe_q;
  logic [1:0] cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= {sda_i, scl_i};
      for (int s = 1; s <= STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign cur        = pipe_q[STAGES-1];
  assign prev       = pipe_q[STAGES];
  assign scl_o      = cur[0];
  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prev[0];
  assign scl_fall_o = ~cur[0] & prev[0];
  assign start_o    = cur[0] & prev[0] & prev[1] & ~cur[1];
  assign stop_o     = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS  = NUM_REGS,
  parameter int unsigned N_PAIRS = NUM_PAIRS,
  parameter int unsigned PTR_W   = $clog2(N_REGS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [PTR_W-1:0]            wr_idx_i,
  input  logic [7:0]                  wr_data_i,
  output logic [N_REGS-1:0][7:0]      regs_o,
  output logic [N_PAIRS-1:0]          pair_en_o
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     val_q <= reg_reset(r, N_REGS);
      else if (wr_en_i && wr_idx_i == PTR_W'(r))       val_q <= wr_data_i;
    end
    assign regs_o[r] = val_q;
  end

  // pair k maps to register k/8, bit 7-(k%8)
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign pair_en_o[p] = regs_o[p/8][7-(p%8)];
  end
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS   = NUM_REGS,
  parameter int unsigned N_HDR    = HDR_BYTES,
  parameter logic [6:0]  ADDR7    = DEV_ADDR,
  parameter logic [7:0]  COUNT    = BLOCK_COUNT,
  parameter int unsigned PTR_W    = $clog2(N_REGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sda_i,
  input  logic                   scl_rise_i,
  input  logic                   scl_fall_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [N_REGS-1:0][7:0] regs_i,
  output logic                   sda_oe_o,
  output logic                   wr_en_o,
  output logic [PTR_W-1:0]       wr_idx_o,
  output logic [7:0]             wr_data_o
);
  localparam int unsigned HDR_W = $clog2(N_HDR + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(N_REGS);
  localparam logic [HDR_W-1:0] HDR_END = HDR_W'(N_HDR);

  smb_state_e       state_q;
  logic [3:0]       bit_q;
  logic [7:0]       sh_q, tx_q;
  logic [PTR_W-1:0] ptr_q;
  logic [HDR_W-1:0] hdr_q;
  logic             rw_q, oe_q, mack_q;
  logic             byte_end, in_range;
  logic [7:0]       rd_byte;

  assign byte_end = scl_fall_i && (bit_q == 4'd8);
  assign in_range = (ptr_q < PTR_END);
  assign rd_byte  = in_range ? regs_i[ptr_q] : 8'hFF;

  assign wr_en_o   = (state_q == ST_WR) && byte_end && (hdr_q == HDR_END) && in_range;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      hdr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      ptr_q   <= '0;
      hdr_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            bit_q <= bit_q + 4'd1;
          end else if (byte_end) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == ADDR7) begin
                rw_q    <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
              if (hdr_q != HDR_END) hdr_q <= hdr_q + 1'b1;
              else if (in_range)    ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q    <= COUNT;
              oe_q    <= ~COUNT[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bit_q <= bit_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bit_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rd_byte;
              oe_q    <= ~rd_byte[7];
              bit_q   <= '0;
              if (in_range) ptr_q <= ptr_q + 1'b1;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS  = NUM_REGS,
  parameter int unsigned N_PAIRS = NUM_PAIRS,
  parameter int unsigned N_HDR   = HDR_BYTES,
  parameter int unsigned N_SYNC  = SYNC_STAGES,
  parameter logic [6:0]  ADDR7   = DEV_ADDR,
  parameter logic [7:0]  COUNT   = BLOCK_COUNT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [N_PAIRS-1:0] pair_en_o
);
  localparam int unsigned PTR_W = $clog2(N_REGS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [N_REGS-1:0][7:0] regs;

  smb_line_sync #(.STAGES(N_SYNC)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_byte_fsm #(
    .N_REGS(N_REGS), .N_HDR(N_HDR), .ADDR7(ADDR7), .COUNT(COUNT), .PTR_W(PTR_W)
  ) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .regs_i(regs),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfg_reg_bank #(.N_REGS(N_REGS), .N_PAIRS(N_PAIRS), .PTR_W(PTR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .regs_o(regs), .pair_en_o
  );
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS  = NUM_REGS,
  parameter int unsigned N_PAIRS = NUM_PAIRS,
  parameter int unsigned PTR_W   = $clog2(N_REGS + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s,
  input logic               start_det,
  input logic               sda_oe,
  input logic               wr_en,
  input logic [PTR_W-1:0]   wr_idx,
  input logic [N_PAIRS-1:0] pair_en,
  input smb_state_e         state,
  input logic [PTR_W-1:0]   ptr
);
  // R12
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe) |-> !scl_s);
  // R8
  wait_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> !sda_oe);
  // R1
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe);
  // R10
  wr_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_idx < PTR_W'(N_REGS)));
  // R5
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en) |-> $stable(pair_en));
  // R9
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_det) |-> (ptr == '0 && state == ST_ADDR));
endmodule

bind smb_cfg_slave smb_cfg_chk #(.N_REGS(N_REGS), .N_PAIRS(N_PAIRS), .PTR_W(PTR_W)) i_chk (
  .clk_i, .rst_ni, .scl_s, .start_det, .sda_oe(sda_oe_o), .wr_en, .wr_idx,
  .pair_en(pair_en_o), .state(i_fsm.state_q), .ptr(i_fsm.ptr_q)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [9:0] pair_en;
  wire sda_line = ~(m_low | sda_oe);

  int total = 0;
  int bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] mreg [6];

  always #5 clk = ~clk;

  smb_cfg_slave i_smb_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pair_en_o(pair_en)
  );

  function automatic logic [9:0] exp_en();
    logic [9:0] e;
    for (int k = 0; k < 10; k++) e[k] = (k < 8) ? mreg[0][7-k] : mreg[1][15-k];
    return e;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: enables follow the register model on every clock
  always @(negedge clk) begin
    if (cmp_en && !done) chk("R11 per-clock enables", int'(pair_en), int'(exp_en()));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(bit b);
    tick(Q); m_low = ~b;
    tick(Q); scl_m = 1'b1;
    tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    tick(Q); m_low = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); b = sda_line;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); m_low = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(2*Q); m_low = 1'b1;
    tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_low = 1'b1;
    tick(Q); scl_m = 1'b1;
    tick(2*Q); m_low = 1'b0;
    tick(2*Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~ack);
  endtask

  // full write frame: address, two header bytes, then data
  task automatic wr_frame(logic [7:0] data[$], bit restart);
    bit ack;
    if (restart) bus_start();
    send_byte(8'hD2, ack); chk("R2 write address ack", ack, 1);
    send_byte(8'h5C, ack); chk("R3 command byte ack", ack, 1);
    send_byte(8'h09, ack); chk("R3 count byte ack", ack, 1);
    chk("R3 header leaves enables", int'(pair_en), int'(exp_en()));
    foreach (data[i]) begin
      cmp_en = 1'b0;
      send_byte(data[i], ack);
      if (i < 6) begin
        chk("R4 data byte ack", ack, 1);
        mreg[i] = data[i];
      end else begin
        chk("R10 surplus byte ack", ack, 1);
      end
      cmp_en = 1'b1;
    end
  endtask

  task automatic rd_frame(int extra);
    bit ack;
    logic [7:0] b;
    int n = 6 + extra;
    bus_start();
    send_byte(8'hD3, ack); chk("R2 read address ack", ack, 1);
    recv_byte(b, 1'b1); chk("R6 byte count", b, 8'h06);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      if (i < 6) chk("R6 register readback", b, mreg[i]);
      else       chk("R7 beyond last register", b, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 5; i++) mreg[i] = 8'hFF;
    mreg[5] = 8'h06;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset enables", int'(pair_en), 10'h3FF);
    chk("R1 reset sda released", sda_oe, 0);
    cmp_en = 1'b1;

    rd_frame(0);                                            // R1 R6 reset values

    bus_start(); wr_frame('{8'h81, 8'h40, 8'h5A, 8'hC3, 8'h3C, 8'h00, 8'h99}, 1'b0); bus_stop();
    chk("R11 decode 0x81/0x40", int'(pair_en), 10'h281);
    rd_frame(2);                                            // R4 R10 R7

    bus_start(); wr_frame('{8'h0F, 8'hC0}, 1'b0); bus_stop(); // R5 partial
    rd_frame(0);

    bus_start(); wr_frame('{}, 1'b0); bus_stop();           // R3 header only
    rd_frame(0);

    // R9: repeated start rewinds to register 0
    bus_start(); wr_frame('{8'h11}, 1'b0); wr_frame('{8'h22}, 1'b1); bus_stop();
    chk("R9 restart rewrites reg0", int'(pair_en), int'(exp_en()));
    rd_frame(0);

    // R2: foreign address ignored for whole transfer
    bus_start();
    send_byte(8'hA0, ack); chk("R2 foreign address nack", ack, 0);
    send_byte(8'h00, ack); chk("R2 no ack after foreign address", ack, 0);
    send_byte(8'h00, ack); chk("R2 still silent", ack, 0);
    bus_stop();
    chk("R2 enables untouched", int'(pair_en), int'(exp_en()));

    // R8: nack ends read, line released; R9 read restart returns count
    bus_start();
    send_byte(8'hD3, ack); chk("R2 read address ack", ack, 1);
    recv_byte(b, 1'b1); chk("R6 byte count", b, 8'h06);
    recv_byte(b, 1'b0); chk("R6 reg0 before nack", b, mreg[0]);
    recv_byte(b, 1'b0); chk("R8 released after nack", b, 8'hFF);
    chk("R8 oe low after nack", sda_oe, 0);
    bus_start();
    send_byte(8'hD3, ack); chk("R9 restart read ack", ack, 1);
    recv_byte(b, 1'b1); chk("R9 restart returns count", b, 8'h06);
    recv_byte(b, 1'b0); chk("R9 restart returns reg0", b, mreg[0]);
    bus_stop();
    chk("R12 oe idle after stop", sda_oe, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule